// File: doc/BRIEF.md
# Synchronous Burst Read Wait Pipeline

This block decides, beat by beat, when read data from a clocked external memory may be captured during a synchronous single or burst read. It works in the fast system clock domain. It derives the external bus clock edge internally as one fast cycle in every `div_i + 1`. On each such edge it registers the device wait pin. It can then apply that sample to the current bus cycle or hold it back by one or two bus cycles. The lag is set by `lag_i`. This lets the memory raise wait ahead of the beat it is about to stall.

A read starts with a start pulse. The first beat completes only when the read access timer has reported completion and the effective wait is low. Each later beat of the burst completes only when the page/burst beat timer has reported completion and the effective wait is low. The timers reside outside the block and report completion with single-edge strobes. A completion that arrives while wait is active is remembered, so the beat is stretched rather than lost. While effective wait is high, the block asserts a counter-freeze and a control-hold output and suppresses capture. The access ends after `burst_len_i + 1` captured beats.

Top module: `burst_wait_pipe`

## Requirements
- R1: A bus edge (`bus_edge_o` high) occurs once every `div_i + 1` fast clock cycles. All inputs except reset are sampled only on bus-edge cycles. `cap_o`, `freeze_o`, `hold_o` and `busy_o` change only in the cycle after a bus edge. `cap_o` is high for exactly that one cycle.
- R2: With `lag_i` = 0, the effective wait at a bus edge is the value of `wait_i` sampled at that same edge.
- R3: With `lag_i` = 1, the effective wait is the value of `wait_i` sampled at the previous bus edge.
- R4: With `lag_i` = 2, the effective wait is the value of `wait_i` sampled two bus edges earlier. A `lag_i` of 3 behaves as 2.
- R5: The first beat is captured at the first bus edge where the effective wait is low and `acc_done_i` has been seen high at this edge or at an earlier edge of the same access.
- R6: Each later beat is captured at the first bus edge where the effective wait is low and `beat_done_i` has been seen high since the previous capture. `acc_done_i` has no effect on these beats.
- R7: While the effective wait is high during an access, `freeze_o` and `hold_o` are high and `cap_o` stays low. A timer completion seen during the stall is kept.
- R8: A start pulse seen while idle begins an access that ends after `burst_len_i + 1` captures, with `burst_len_i` latched at start. `busy_o` goes low together with the last `cap_o`. Start pulses during an access and timer strobes while idle are ignored.
- R9: With `mon_en_i` low, the effective wait is always low. Capture follows the timers alone, and `freeze_o` and `hold_o` stay low.
- R10: After synchronous reset all outputs are low, and the wait history is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Bus clock divider; one bus edge per div_i+1 fast cycles |
| mon_en_i | input | 1 | Read wait monitoring enable |
| lag_i | input | 2 | Wait pipeline depth in bus cycles (0, 1, 2; 3 acts as 2) |
| wait_i | input | 1 | Device wait pin, high = stall |
| start_i | input | 1 | Starts a read access |
| acc_done_i | input | 1 | Read access time elapsed strobe |
| beat_done_i | input | 1 | Page/burst beat time elapsed strobe |
| burst_len_i | input | LEN_W | Number of beats minus one |
| bus_edge_o | output | 1 | Rising bus clock edge indication |
| cap_o | output | 1 | Data capture strobe, one fast cycle |
| freeze_o | output | 1 | Cycle counter freeze |
| hold_o | output | 1 | Control signal hold |
| busy_o | output | 1 | Access in progress |

## Verification
Two functions can fall on the same bus edge: a timer completion that would capture a beat, and an effective wait that stalls it. The bench provokes this by raising a timer strobe while a wait sample, taken earlier because of the lag, is still active. It does this in directed sequences and also in random runs that use every lag and several dividers. The bench judges the result by checking that no capture appears at that edge. Freeze and hold must be high at that edge. Capture must then follow at the first later edge whose delayed wait is low, with no new strobe needed.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_BURST = 2'd2
    } phase_e;

    typedef struct packed {
        logic cap;
        logic freeze;
        logic hold;
    } beat_out_s;

    localparam int MAX_LAG = 2;

    function automatic logic [1:0] clamp_lag(input logic [1:0] lag, input int unsigned lim);
        logic [1:0] r;
        r = (int'(lag) > lim) ? 2'(lim) : lag;
        return r;
    endfunction

endpackage

// File: rtl/bwp_tick_gen.sv
module bwp_tick_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && div_i != '0) |=> !tick_o);

endmodule

// File: rtl/bwp_wait_line.sv
module bwp_wait_line #(
    parameter int MAX_LAG = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       mon_i,
    input  logic       wait_i,
    input  logic [1:0] lag_i,
    output logic       wait_eff_o
);
    import bwp_pkg::*;

    logic [MAX_LAG:0] tap;
    logic [1:0]       lag_c;

    assign tap[0] = wait_i;

    generate
        for (genvar k = 1; k <= MAX_LAG; k++) begin : g_stage
            logic stage_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q <= 1'b0;
                end else if (tick_i && mon_i) begin
                    stage_q <= tap[k-1];
                end
            end
            assign tap[k] = stage_q;
        end
    endgenerate

    assign lag_c      = clamp_lag(lag_i, MAX_LAG);
    assign wait_eff_o = mon_i & tap[lag_c];

    // R3
    first_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && mon_i) |=> (tap[1] == $past(wait_i)));

    // R9
    mon_off_chk: assert property (@(posedge clk) disable iff (rst)
        !mon_i |-> !wait_eff_o);

endmodule

// File: rtl/bwp_beat_seq.sv
module bwp_beat_seq #(
    parameter int LEN_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic                wait_eff_i,
    input  logic                start_i,
    input  logic                acc_done_i,
    input  logic                beat_done_i,
    input  logic [LEN_W-1:0]    burst_len_i,
    output bwp_pkg::beat_out_s  out_o,
    output logic                busy_o
);
    import bwp_pkg::*;

    phase_e           phase_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    logic             acc_pend_q;
    logic             beat_pend_q;
    beat_out_s        out_q;

    logic in_first;
    logic active;
    logic time_ok;
    logic take;
    logic last_beat;

    always_comb begin
        in_first  = (phase_q == PH_FIRST);
        active    = (phase_q != PH_IDLE);
        time_ok   = in_first ? (acc_pend_q | acc_done_i) : (beat_pend_q | beat_done_i);
        take      = tick_i & active & time_ok & ~wait_eff_i;
        last_beat = (cnt_q == len_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            len_q       <= '0;
            acc_pend_q  <= 1'b0;
            beat_pend_q <= 1'b0;
            out_q       <= '0;
        end else if (tick_i) begin
            out_q.cap    <= take;
            out_q.freeze <= active & wait_eff_i;
            out_q.hold   <= active & wait_eff_i;
            if (!active) begin
                if (start_i) begin
                    phase_q     <= PH_FIRST;
                    cnt_q       <= '0;
                    len_q       <= burst_len_i;
                    acc_pend_q  <= 1'b0;
                    beat_pend_q <= 1'b0;
                end
            end else if (take) begin
                acc_pend_q  <= 1'b0;
                beat_pend_q <= 1'b0;
                if (last_beat) begin
                    phase_q <= PH_IDLE;
                end else begin
                    phase_q <= PH_BURST;
                    cnt_q   <= cnt_q + 1'b1;
                end
            end else if (in_first) begin
                acc_pend_q <= acc_pend_q | acc_done_i;
            end else begin
                beat_pend_q <= beat_pend_q | beat_done_i;
            end
        end else begin
            out_q.cap <= 1'b0;
        end
    end

    assign out_o  = out_q;
    assign busy_o = active;

    // R7
    cap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_q.cap |-> !out_q.freeze);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q <= len_q));

    // R1
    freeze_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(out_q.freeze));

    // R8
    idle_nocap_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> !out_q.cap);

    // R1
    cap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !out_q.cap);

endmodule

// File: rtl/burst_wait_pipe.sv
module burst_wait_pipe #(
    parameter int DIV_W = 4,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             mon_en_i,
    input  logic [1:0]       lag_i,
    input  logic             wait_i,
    input  logic             start_i,
    input  logic             acc_done_i,
    input  logic             beat_done_i,
    input  logic [LEN_W-1:0] burst_len_i,
    output logic             bus_edge_o,
    output logic             cap_o,
    output logic             freeze_o,
    output logic             hold_o,
    output logic             busy_o
);
    import bwp_pkg::*;

    logic      tick;
    logic      wait_eff;
    beat_out_s beat_out;

    bwp_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_i),
        .tick_o (tick)
    );

    bwp_wait_line #(.MAX_LAG(MAX_LAG)) u_line (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick),
        .mon_i      (mon_en_i),
        .wait_i     (wait_i),
        .lag_i      (lag_i),
        .wait_eff_o (wait_eff)
    );

    bwp_beat_seq #(.LEN_W(LEN_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick),
        .wait_eff_i  (wait_eff),
        .start_i     (start_i),
        .acc_done_i  (acc_done_i),
        .beat_done_i (beat_done_i),
        .burst_len_i (burst_len_i),
        .out_o       (beat_out),
        .busy_o      (busy_o)
    );

    assign bus_edge_o = tick;
    assign cap_o      = beat_out.cap;
    assign freeze_o   = beat_out.freeze;
    assign hold_o     = beat_out.hold;

    // R7
    hold_track_chk: assert property (@(posedge clk) disable iff (rst)
        freeze_o |-> (hold_o && busy_o || hold_o && !cap_o));

endmodule

// File: tb/burst_wait_pipe_bench.sv
module burst_wait_pipe_bench;
    localparam int DIV_W = 4;
    localparam int LEN_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_i = '0;
    logic             mon_en_i = 1'b0;
    logic [1:0]       lag_i = '0;
    logic             wait_i = 1'b0;
    logic             start_i = 1'b0;
    logic             acc_done_i = 1'b0;
    logic             beat_done_i = 1'b0;
    logic [LEN_W-1:0] burst_len_i = '0;
    logic             bus_edge_o, cap_o, freeze_o, hold_o, busy_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // bench model state
    bit m_act, m_first, m_ap, m_bp, h1, h2;
    int m_cnt, m_len;
    bit e_cap, e_fz;

    always #2 clk = ~clk;

    burst_wait_pipe #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_burst_wait_pipe (
        .clk(clk), .rst(rst), .div_i(div_i), .mon_en_i(mon_en_i), .lag_i(lag_i),
        .wait_i(wait_i), .start_i(start_i), .acc_done_i(acc_done_i),
        .beat_done_i(beat_done_i), .burst_len_i(burst_len_i),
        .bus_edge_o(bus_edge_o), .cap_o(cap_o), .freeze_o(freeze_o),
        .hold_o(hold_o), .busy_o(busy_o)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit eff_wait(input bit w);
        int l;
        l = (lag_i > 2) ? 2 : int'(lag_i);
        if (!mon_en_i) return 1'b0;
        if (l == 0) return w;
        if (l == 1) return h1;
        return h2;
    endfunction

    task automatic do_reset(input int dv, input int lg, input bit mon, input int len);
        @(negedge clk);
        rst = 1'b1;
        div_i = DIV_W'(dv); lag_i = 2'(lg); mon_en_i = mon; burst_len_i = LEN_W'(len);
        wait_i = 0; start_i = 0; acc_done_i = 0; beat_done_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_act = 0; m_first = 0; m_ap = 0; m_bp = 0; h1 = 0; h2 = 0; m_cnt = 0; m_len = 0;
        // R10: reset state
        check("R10", "cap", cap_o, 1'b0);
        check("R10", "freeze", freeze_o, 1'b0);
        check("R10", "hold", hold_o, 1'b0);
        check("R10", "busy", busy_o, 1'b0);
    endtask

    // one bus edge: drive, model, then check on the following fast cycle
    task automatic step(input bit w, input bit a, input bit b, input bit s, input string tag);
        bit ef, ok;
        while (!bus_edge_o) @(negedge clk);
        wait_i = w; acc_done_i = a; beat_done_i = b; start_i = s;
        ef = eff_wait(w);
        if (mon_en_i) begin h2 = h1; h1 = w; end
        e_cap = 0;
        e_fz  = m_act & ef;
        if (m_act) begin
            ok = m_first ? (m_ap | a) : (m_bp | b);
            if (ok && !ef) begin
                e_cap = 1; m_ap = 0; m_bp = 0;
                if (m_cnt == m_len) m_act = 0;
                else begin m_cnt++; m_first = 0; end
            end else if (m_first) m_ap = m_ap | a;
            else m_bp = m_bp | b;
        end else if (s) begin
            m_act = 1; m_first = 1; m_cnt = 0; m_len = int'(burst_len_i); m_ap = 0; m_bp = 0;
        end
        @(negedge clk);
        check(tag, "cap", cap_o, e_cap);
        check(tag, "freeze", freeze_o, e_fz);
        check(tag, "hold", hold_o, e_fz);
        check(tag, "busy", busy_o, m_act);
    endtask

    task automatic scen(input int dv, input int lg, input bit mon, input int len,
                        input int n, input int pw, input string tag);
        do_reset(dv, lg, mon, len);
        for (int i = 0; i < n; i++) begin
            step(($urandom % 100) < pw, ($urandom % 3) == 0, ($urandom % 2) == 0,
                 ($urandom % 3) == 0, tag);
            if (!m_act) burst_len_i = LEN_W'($urandom % 4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int gap;
        void'($urandom(32'd4242));

        // R1: bus edge spacing for div=2
        do_reset(2, 0, 1, 0);
        while (!bus_edge_o) @(negedge clk);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!bus_edge_o);
        total++;
        if (gap != 3) begin bad++; $display("FAIL R1 gap actual=%0d expected=3", gap); end

        // R5: first beat waits for access timer, then wait low
        do_reset(0, 0, 1, 0);
        step(0, 0, 0, 1, "R5");
        step(0, 0, 1, 0, "R5");
        step(0, 1, 0, 0, "R5");
        check("R5", "single beat done busy", busy_o, 1'b0);

        // R7: strobe during stall is remembered (lag 0)
        do_reset(0, 0, 1, 1);
        step(0, 0, 0, 1, "R7");
        step(1, 1, 0, 0, "R7");
        check("R7", "stall freeze", freeze_o, 1'b1);
        step(0, 0, 0, 0, "R7");
        check("R7", "captured after stall", cap_o, 1'b1);
        // R6: access strobe does not complete a burst beat
        step(0, 1, 0, 0, "R6");
        step(0, 0, 1, 0, "R6");
        check("R8", "two beats then idle", busy_o, 1'b0);

        // R3: wait sampled one edge ahead collides with timer strobe
        do_reset(1, 1, 1, 0);
        step(0, 0, 0, 1, "R3");
        step(1, 0, 0, 0, "R3");
        step(0, 1, 0, 0, "R3");
        check("R3", "delayed wait blocks cap", cap_o, 1'b0);
        step(0, 0, 0, 0, "R3");

        // R4: lag 3 acts as 2
        do_reset(0, 3, 1, 0);
        step(1, 0, 0, 1, "R4");
        step(0, 1, 0, 0, "R4");
        step(0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, "R4");

        // R8: start while busy ignored, strobes while idle ignored
        do_reset(0, 0, 1, 2);
        step(0, 1, 1, 0, "R8");
        step(0, 0, 0, 1, "R8");
        step(0, 1, 0, 1, "R8");
        step(0, 0, 1, 1, "R8");
        step(0, 0, 1, 1, "R8");
        step(0, 0, 0, 0, "R8");

        // random runs across lags, dividers, monitoring
        scen(0, 0, 1, 1, 300, 30, "R2");
        scen(1, 1, 1, 2, 300, 30, "R3");
        scen(2, 2, 1, 3, 300, 30, "R4");
        scen(0, 3, 1, 0, 200, 40, "R4");
        scen(3, 1, 1, 3, 200, 20, "R6");
        scen(1, 2, 0, 2, 200, 50, "R9");
        scen(0, 1, 1, 1, 300, 60, "R7");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule